// File: doc/BRIEF.md
# Two-level page table walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table held in ordinary memory. The top ten bits of the address select an entry in the outer table, which begins at a base address given on an input. That entry points to an inner table. The next ten bits select an entry there. The inner entry supplies the frame number, and the low twelve bits of the virtual address are appended to it unchanged.

A requester, typically a translation cache on a miss, hands over one address at a time through a valid/ready handshake. It gets back either a physical address with the permission bits of the final entry, or a fault that says which level held an invalid entry. Every response echoes the virtual address. Toward memory the block issues reads through a valid/ready request and a one-cycle response strobe. It never has more than one read outstanding, and the two reads of a walk are strictly dependent.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 while `rsp_valid` and `mem_req_valid` are 0.
- R2: The first read of a walk goes to `pt_base + 4*p1`, where p1 is `req_va[31:22]`.
- R3: A table entry is 32 bits, with bit 0 as its valid flag, bits 3:1 as its permissions and bits 31:12 as a frame number. When the outer entry is valid, the second read goes to `{outer[31:12], 12'h000} + 4*p2`, where p2 is `req_va[21:12]`. Bits 11:0 of the outer entry do not affect that address.
- R4: When both entries are valid, the response has `rsp_fault`=0, `rsp_pa` = `{inner[31:12], req_va[11:0]}` and `rsp_perm` = `inner[3:1]`.
- R5: An outer entry with bit 0 clear ends the walk after exactly one read. The response has `rsp_fault`=1, `rsp_fault_lvl`=0, and `rsp_pa` and `rsp_perm` both zero.
- R6: An inner entry with bit 0 clear gives a response with `rsp_fault`=1 and `rsp_fault_lvl`=1 after exactly two reads. `rsp_pa` and `rsp_perm` are zero.
- R7: From the cycle a request is accepted until its response is taken, `req_ready` stays 0. No more than one memory read is outstanding, and a walk makes no more than two reads.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and `mem_addr` stay unchanged.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, every response field stays unchanged. The cycle after `rsp_ready` is seen, `req_ready` returns to 1.
- R10: `rsp_va` equals the accepted `req_va` on every response, whether it reports success or a fault.
- R11: A `mem_rsp_valid` pulse that arrives while no read is outstanding has no effect on the next translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pt_base | input | 32 | Byte address of the outer table; sampled when a request is accepted |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_fault | output | 1 | 1 when the walk hit an invalid entry |
| rsp_fault_lvl | output | 1 | Level of the failing entry: 0 outer, 1 inner |
| rsp_pa | output | 32 | Physical address (zero on a fault) |
| rsp_perm | output | 3 | Permission bits of the inner entry (zero on a fault) |
| rsp_va | output | 32 | Echo of the translated virtual address |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | One-cycle strobe: read data present |
| mem_rsp_data | input | 32 | Table entry returned by memory |

## Verification
A wrong state or a wrong latched base shows up first on `mem_addr`, at the first accepted read of the walk, well before any response. A bad level decision shows up at the response one cycle after the deciding read returns. It appears as a missing or extra read, a wrong fault level, or a wrong frame. The bench sweeps every outer index and every inner index against a table whose entries are computed from their own addresses. Every address and every result can therefore be predicted without reference to the design. Varying ready and latency patterns, held responses and stray memory strobes expose a handshake slip within the same walk.

// File: rtl/pw_pkg.sv
package pw_pkg;

  // Walk states; order matters only for readability
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUTER,
    ST_RD_INNER,
    ST_DONE,
    ST_FAULT
  } walk_st_e;

  // Table-entry field positions (decoded by pw_pte_dec)
  localparam int ENT_VALID_BIT = 0;
  localparam int ENT_PERM_LSB  = 1;
  localparam int ENT_PERM_W    = 3;

endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int IDX_W     = 10,
  parameter int OFF_W     = 12,
  parameter int ENT_BYTES = 4
) (
  input  logic                  lvl_inner,
  input  logic [VA_W-1:0]       va,
  input  logic [PA_W-1:0]       root_base,
  input  logic [PA_W-OFF_W-1:0] next_frame,
  output logic [PA_W-1:0]       ent_addr
);
  localparam int NLVL   = 2;
  localparam int ENT_SH = $clog2(ENT_BYTES);

  // Index of a level: level 0 sits just below the top of the address
  function automatic logic [IDX_W-1:0] level_index(input logic [VA_W-1:0] v, input int lvl);
    return v[OFF_W + (NLVL-1-lvl)*IDX_W +: IDX_W];
  endfunction

  // Entry slot inside a table
  function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] base,
                                                input logic [IDX_W-1:0] idx);
    return base + (PA_W'(idx) << ENT_SH);
  endfunction

  logic [PA_W-1:0] cand [NLVL];

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    if (g == 0) begin : g_root
      assign cand[g] = slot_addr(root_base, level_index(va, g));
    end else begin : g_next
      assign cand[g] = slot_addr({next_frame, {OFF_W{1'b0}}}, level_index(va, g));
    end
  end

  assign ent_addr = lvl_inner ? cand[1] : cand[0];

  // R3
  always_comb inner_aligned_chk: assert (!lvl_inner || ent_addr[OFF_W-1:ENT_SH] == va[OFF_W +: IDX_W]);

endmodule

// File: rtl/pw_pte_dec.sv
module pw_pte_dec
  import pw_pkg::*;
#(
  parameter int PTE_W = 32,
  parameter int OFF_W = 12
) (
  input  logic [PTE_W-1:0]       pte,
  output logic                   ent_ok,
  output logic [ENT_PERM_W-1:0]  ent_perm,
  output logic [PTE_W-OFF_W-1:0] ent_frame
);
  localparam int RSV_LSB = ENT_PERM_LSB + ENT_PERM_W;

  logic [OFF_W-RSV_LSB-1:0] unused_rsvd;

  assign ent_ok      = pte[ENT_VALID_BIT];
  assign ent_perm    = pte[ENT_PERM_LSB +: ENT_PERM_W];
  assign ent_frame   = pte[PTE_W-1:OFF_W];
  assign unused_rsvd = pte[OFF_W-1:RSV_LSB];

endmodule

// File: rtl/pw_fsm.sv
module pw_fsm
  import pw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PA_W-1:0]        pt_base,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_va,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic                   rsp_fault,
  output logic                   rsp_fault_lvl,
  output logic [PA_W-1:0]        rsp_pa,
  output logic [ENT_PERM_W-1:0]  rsp_perm,
  output logic [VA_W-1:0]        rsp_va,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  input  logic [PA_W-1:0]        mem_addr,
  input  logic                   mem_rsp_valid,
  input  logic                   ent_ok,
  input  logic [ENT_PERM_W-1:0]  ent_perm,
  input  logic [PA_W-OFF_W-1:0]  ent_frame,
  output logic                   lvl_inner,
  output logic [VA_W-1:0]        va_q,
  output logic [PA_W-1:0]        root_q,
  output logic [PA_W-OFF_W-1:0]  nframe_q
);
  localparam int FRM_W = PA_W - OFF_W;

  walk_st_e              st_q;
  logic                  issued_q;
  logic [PA_W-1:0]       pa_q;
  logic [ENT_PERM_W-1:0] perm_q;
  logic                  flvl_q;

  // Named internal events
  logic in_read, evt_accept, evt_fetch, evt_take;
  logic evt_l1_bad, evt_l1_ok, evt_l2_bad, evt_l2_ok, evt_rsp_done;

  assign in_read      = (st_q == ST_RD_OUTER) || (st_q == ST_RD_INNER);
  assign evt_accept   = (st_q == ST_IDLE) && req_valid;
  assign evt_fetch    = in_read && !issued_q && mem_req_ready;
  assign evt_take     = in_read && issued_q && mem_rsp_valid;
  assign evt_l1_bad   = evt_take && (st_q == ST_RD_OUTER) && !ent_ok;
  assign evt_l1_ok    = evt_take && (st_q == ST_RD_OUTER) && ent_ok;
  assign evt_l2_bad   = evt_take && (st_q == ST_RD_INNER) && !ent_ok;
  assign evt_l2_ok    = evt_take && (st_q == ST_RD_INNER) && ent_ok;
  assign evt_rsp_done = rsp_valid && rsp_ready;

  // Physical address from frame and page offset
  function automatic logic [PA_W-1:0] join_pa(input logic [FRM_W-1:0] frm,
                                              input logic [VA_W-1:0] v);
    return {frm, v[OFF_W-1:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      issued_q <= 1'b0;
      va_q     <= '0;
      root_q   <= '0;
      nframe_q <= '0;
      pa_q     <= '0;
      perm_q   <= '0;
      flvl_q   <= 1'b0;
    end else begin
      if (evt_accept) begin
        va_q     <= req_va;
        root_q   <= pt_base;
        issued_q <= 1'b0;
        pa_q     <= '0;
        perm_q   <= '0;
        flvl_q   <= 1'b0;
        st_q     <= ST_RD_OUTER;
      end else if (evt_fetch) begin
        issued_q <= 1'b1;
      end else if (evt_l1_bad) begin
        issued_q <= 1'b0;
        flvl_q   <= 1'b0;
        st_q     <= ST_FAULT;
      end else if (evt_l1_ok) begin
        issued_q <= 1'b0;
        nframe_q <= ent_frame;
        st_q     <= ST_RD_INNER;
      end else if (evt_l2_bad) begin
        issued_q <= 1'b0;
        flvl_q   <= 1'b1;
        st_q     <= ST_FAULT;
      end else if (evt_l2_ok) begin
        issued_q <= 1'b0;
        pa_q     <= join_pa(ent_frame, va_q);
        perm_q   <= ent_perm;
        st_q     <= ST_DONE;
      end else if (evt_rsp_done) begin
        st_q     <= ST_IDLE;
      end
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign rsp_valid     = (st_q == ST_DONE) || (st_q == ST_FAULT);
  assign rsp_fault     = (st_q == ST_FAULT);
  assign rsp_fault_lvl = flvl_q;
  assign rsp_pa        = pa_q;
  assign rsp_perm      = perm_q;
  assign rsp_va        = va_q;
  assign mem_req_valid = in_read && !issued_q;
  assign lvl_inner     = (st_q == ST_RD_INNER);

  // R1
  always_comb reset_idle_chk: assert (rst_n || (req_ready && !rsp_valid && !mem_req_valid));

  // R5
  outer_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_l1_bad |=> rsp_valid && rsp_fault && !rsp_fault_lvl && rsp_pa == '0);

  // R6
  inner_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_l2_bad |=> rsp_valid && rsp_fault && rsp_fault_lvl && rsp_pa == '0);

  // R4
  good_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_l2_ok |=> rsp_valid && !rsp_fault && rsp_pa[FRM_W+OFF_W-1:OFF_W] == $past(ent_frame));

  // R7
  one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (mem_req_valid || rsp_valid)));

  // R7
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fetch |=> !mem_req_valid);

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)
      && $stable(rsp_fault_lvl) && $stable(rsp_perm) && $stable(rsp_va));

  // R9
  rsp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rsp_done |=> req_ready && !rsp_valid);

  // R10
  va_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> rsp_va == $past(req_va));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PA_W-1:0]       pt_base,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_va,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_fault,
  output logic                  rsp_fault_lvl,
  output logic [PA_W-1:0]       rsp_pa,
  output logic [ENT_PERM_W-1:0] rsp_perm,
  output logic [VA_W-1:0]       rsp_va,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [PA_W-1:0]       mem_addr,
  input  logic                  mem_rsp_valid,
  input  logic [PA_W-1:0]       mem_rsp_data
);
  localparam int FRM_W     = PA_W - OFF_W;
  localparam int ENT_BYTES = PA_W / 8;

  logic                  ent_ok;
  logic [ENT_PERM_W-1:0] ent_perm;
  logic [FRM_W-1:0]      ent_frame;
  logic                  lvl_inner;
  logic [VA_W-1:0]       va_q;
  logic [PA_W-1:0]       root_q;
  logic [FRM_W-1:0]      nframe_q;

  pw_pte_dec #(.PTE_W(PA_W), .OFF_W(OFF_W)) u_dec (
    .pte       (mem_rsp_data),
    .ent_ok    (ent_ok),
    .ent_perm  (ent_perm),
    .ent_frame (ent_frame)
  );

  pw_addr_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ENT_BYTES(ENT_BYTES)
  ) u_agen (
    .lvl_inner  (lvl_inner),
    .va         (va_q),
    .root_base  (root_q),
    .next_frame (nframe_q),
    .ent_addr   (mem_addr)
  );

  pw_fsm #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .pt_base       (pt_base),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (req_va),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_fault     (rsp_fault),
    .rsp_fault_lvl (rsp_fault_lvl),
    .rsp_pa        (rsp_pa),
    .rsp_perm      (rsp_perm),
    .rsp_va        (rsp_va),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .ent_ok        (ent_ok),
    .ent_perm      (ent_perm),
    .ent_frame     (ent_frame),
    .lvl_inner     (lvl_inner),
    .va_q          (va_q),
    .root_q        (root_q),
    .nframe_q      (nframe_q)
  );

endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pt_base = 32'h0010_0000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault, rsp_fault_lvl;
  logic [31:0] rsp_pa, rsp_va;
  logic [2:0]  rsp_perm;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_fault_lvl(rsp_fault_lvl), .rsp_pa(rsp_pa), .rsp_perm(rsp_perm), .rsp_va(rsp_va),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Page tables computed from addresses: outer tables anywhere below 0x4000_0000,
  // inner table for outer index p1 at 0x4000_0000 + p1*4096
  function automatic bit outer_ok(input int p1);
    return (p1 % 5) != 3;
  endfunction
  function automatic bit inner_ok(input int p1, input int p2);
    return ((p1 + p2) % 7) != 6;
  endfunction
  function automatic logic [19:0] inner_frame(input int p1, input int p2);
    return 20'(p1 * 613 + p2 * 29 + 7);
  endfunction
  function automatic logic [2:0] inner_perm(input int p1, input int p2);
    return 3'((p1 ^ p2) & 7);
  endfunction
  function automatic logic [31:0] table_word(input logic [31:0] a);
    if (a[31:28] == 4'h4) begin
      int p1 = int'(a[21:12]);
      int p2 = int'(a[11:2]);
      return {inner_frame(p1, p2), 8'h3C, inner_perm(p1, p2), inner_ok(p1, p2)};
    end else begin
      int p1 = int'((a - pt_base) >> 2);
      return (32'h4000_0000 + (32'(p1) << 12)) | 32'h0000_0A5A | 32'(outer_ok(p1));
    end
  endfunction

  // Memory model, driven on the falling edge
  int          cyc = 0;
  int          lat = 0;
  int          n_reads = 0;
  logic [31:0] rd_addr [2];
  logic [31:0] pend = '0;
  bit          inject = 1'b0;

  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (inject) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 32'hFFFF_FFFF;
      inject = 1'b0;
    end else if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pend;
      end
    end
    mem_req_ready = (cyc % 4) != 2;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (n_reads < 2) rd_addr[n_reads] = mem_addr;
      n_reads++;
      pend = table_word(mem_addr);
      lat = 1 + (cyc % 3);
    end
  end

  // Watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic stray_strobe();
    @(posedge clk);
    inject = 1'b1;
    @(negedge clk);
  endtask

  task automatic walk(input logic [31:0] va, input bit hold);
    int p1 = int'(va[31:22]);
    int p2 = int'(va[21:12]);
    bit busy_bad = 1'b0;
    bit done = 1'b0;
    logic [31:0] cap_pa, cap_va;
    logic [2:0] cap_perm;
    logic cap_f, cap_l;
    @(negedge clk);
    n_reads = 0;
    req_va = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_va = ~va;
    for (int t = 0; t < 300; t++) begin
      if (rsp_valid) begin done = 1'b1; break; end
      if (req_ready) busy_bad = 1'b1;
      @(negedge clk);
    end
    chk(done, "R7 response timeout", 32'(done), 32'd1);
    if (!done) return;
    chk(!busy_bad, "R7 req_ready low while busy", 32'(busy_bad), 32'd0);
    chk(rsp_va == va, "R10 va echo", rsp_va, va);
    chk(n_reads >= 1 && rd_addr[0] == pt_base + 32'(p1) * 4, "R2 outer read address",
        rd_addr[0], pt_base + 32'(p1) * 4);
    if (!outer_ok(p1)) begin
      chk(n_reads == 1, "R5 single read on outer fault", 32'(n_reads), 32'd1);
      chk(rsp_fault && !rsp_fault_lvl, "R5 outer fault level",
          {30'd0, rsp_fault, rsp_fault_lvl}, 32'd2);
      chk(rsp_pa == '0 && rsp_perm == '0, "R5 zero result on fault", rsp_pa, 32'd0);
    end else begin
      chk(n_reads == 2, "R7 two reads per walk", 32'(n_reads), 32'd2);
      chk(rd_addr[1] == 32'h4000_0000 + (32'(p1) << 12) + 32'(p2) * 4, "R3 inner read address",
          rd_addr[1], 32'h4000_0000 + (32'(p1) << 12) + 32'(p2) * 4);
      if (!inner_ok(p1, p2)) begin
        chk(rsp_fault && rsp_fault_lvl, "R6 inner fault level",
            {30'd0, rsp_fault, rsp_fault_lvl}, 32'd3);
        chk(rsp_pa == '0 && rsp_perm == '0, "R6 zero result on fault", rsp_pa, 32'd0);
      end else begin
        chk(!rsp_fault, "R4 no fault", 32'(rsp_fault), 32'd0);
        chk(rsp_pa == {inner_frame(p1, p2), va[11:0]}, "R4 physical address",
            rsp_pa, {inner_frame(p1, p2), va[11:0]});
        chk(rsp_perm == inner_perm(p1, p2), "R4 permissions",
            32'(rsp_perm), 32'(inner_perm(p1, p2)));
      end
    end
    if (hold) begin
      cap_pa = rsp_pa; cap_va = rsp_va; cap_perm = rsp_perm; cap_f = rsp_fault; cap_l = rsp_fault_lvl;
      @(negedge clk);
      @(negedge clk);
      chk(rsp_valid && rsp_pa == cap_pa && rsp_va == cap_va && rsp_perm == cap_perm
          && rsp_fault == cap_f && rsp_fault_lvl == cap_l, "R9 response held", rsp_pa, cap_pa);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R9 release after take", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset state",
        {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 idle after reset",
        {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'd4);

    // Corners
    walk(32'h0000_0000, 1'b1);
    walk(32'hFFFF_FFFF, 1'b1);
    walk(32'h00C0_0ABC, 1'b1);                  // p1=3: outer invalid (R5)
    walk({10'd1, 10'd5, 12'h123}, 1'b1);        // p1+p2=6: inner invalid (R6)

    // R11: stray strobes while idle must not disturb the next walk
    for (int k = 0; k < 6; k++) begin
      stray_strobe();
      walk({10'(k * 171 + 1), 10'(k * 97), 12'(k * 501)}, 1'b0);
    end

    // Sweep every outer index
    for (int i = 0; i < 1024; i++)
      walk({10'(i), 10'((i * 7) % 1024), 12'((i * 3) % 4096)}, (i % 64) == 0);

    // Sweep every inner index with a different table base
    pt_base = 32'h1230_0000;
    for (int j = 0; j < 1024; j++)
      walk({10'd1, 10'(j), 12'(4095 - j)}, (j % 128) == 5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule